// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A fetch stage presents a program counter. In the same cycle the block returns a taken or not-taken guess and a metadata word. The pipeline keeps that word and hands it back when the branch resolves.

The guess comes from four tables that are read in parallel. One is a base table of 2-bit counters, indexed directly by the PC and never tag-checked. The other three are tagged tables of 64 entries. Each is indexed and tagged by hashes that mix the PC with the newest 4, 8 or 16 bits of global branch history. Of the tagged tables that hit, the one with the longest history supplies the direction. When none hits, the base table decides.

The block keeps its own 16-bit speculative history. Every guess is shifted into it. When a resolved branch turns out to have been mispredicted, the history is rebuilt from the checkpoint carried in the metadata. A misprediction also places a new entry in a longer table, so that repeating patterns and correlated branches are learned over time.

Top module: `tage_predictor`

## Requirements
- R1: After reset, every PC predicts not-taken with provider field 0, and the history checkpoint in the metadata is 0.
- R2: The base counter is 2 bits wide, predicts taken when its MSB is 1 and saturates at 0 and 3. It is trained only by updates whose provider field is 0.
- R3: A tagged table hits when its stored tag equals the tag computed from the PC and history. A computed tag is never 0, so an entry left at its reset tag of 0 never hits. The provider is the hitting table with the longest history, and a 3-bit two's-complement counter predicts taken when it is 0 or greater.
- R4: On a misprediction whose provider is 0, 1 or 2, the lowest longer table whose entry has usefulness 0 receives the new tag and a weak counter: 000 for taken, 111 for not-taken. When every such entry has usefulness 1, those entries have their usefulness cleared instead.
- R5: On update, the provider's counter moves one step toward the outcome and saturates at 011 and 100. When the provider's direction and the alternate direction differ, the provider's usefulness bit becomes 1 if the provider was right and 0 otherwise.
- R6: Each prediction shifts its own direction into bit 0 of the speculative history.
- R7: An update whose outcome differs from metadata bit 0 sets the history to {checkpoint[14:0], outcome}. This restore overrides a prediction shift in the same cycle.
- R8: The metadata layout is: bits [19:4] are the history checkpoint taken before the shift, [3:2] the provider (0 = base, 1..3 = table with history 4, 8, 16), [1] the alternate direction, and [0] the predicted direction.
- R9: A branch repeating taken, taken, taken, not-taken reaches zero mispredictions after training.
- R10: A branch whose outcome equals that of the branch just before it is predicted with zero mispredictions after training, even though the earlier branch follows an irregular pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A prediction is requested this cycle |
| pred_pc | input | 12 | PC of the branch being fetched |
| pred_taken | output | 1 | Predicted direction (combinational) |
| pred_meta | output | 20 | Metadata to return at update |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 12 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_meta | input | 20 | Metadata captured when this branch was predicted |

## Verification
The hardest case to reach is a lookup that hits one particular tagged entry, because that needs the exact same PC together with the exact same history bits. The bench resolves a branch wrongly so that the history is rebuilt from a known checkpoint. It then issues not-taken probes of an unrelated PC until the low history bits return to zero, and looks up the branch again. It also crafts update metadata directly, which trains a chosen counter without disturbing the history. The learning cases are checked by counting mispredictions over the late iterations of long loop and correlated sequences.

// File: rtl/tage_pkg.sv
package tage_pkg;
  localparam int unsigned NUM_TAGGED = 3;
  localparam int unsigned PROV_W = 2;

  typedef enum logic [PROV_W-1:0] {
    PROV_BASE = 2'd0,
    PROV_T1   = 2'd1,
    PROV_T2   = 2'd2,
    PROV_T3   = 2'd3
  } prov_e;
endpackage

// File: rtl/bp_fold.sv
module bp_fold #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  in_bits,
  output logic [OUT_W-1:0] folded
);
  always_comb begin
    folded = '0;
    for (int i = 0; i < IN_W; i++) begin
      folded[i % OUT_W] = folded[i % OUT_W] ^ in_bits[i];
    end
  end
endmodule

// File: rtl/bp_hash.sv
module bp_hash #(
  parameter int PC_W     = 12,
  parameter int HIST_LEN = 4,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 8
) (
  input  logic [PC_W-1:0]     pc,
  input  logic [HIST_LEN-1:0] hist,
  output logic [IDX_W-1:0]    idx,
  output logic [TAG_W-1:0]    tag
);
  logic [IDX_W-1:0] hf_idx;
  logic [TAG_W-1:0] hf_tag;
  logic [TAG_W-1:0] tag_raw;

  bp_fold #(.IN_W(HIST_LEN), .OUT_W(IDX_W)) u_fold_idx (.in_bits(hist), .folded(hf_idx));
  bp_fold #(.IN_W(HIST_LEN), .OUT_W(TAG_W)) u_fold_tag (.in_bits(hist), .folded(hf_tag));

  always_comb begin
    idx     = pc[IDX_W-1:0] ^ pc[2*IDX_W-1:IDX_W] ^ hf_idx;
    tag_raw = pc[PC_W-1 -: TAG_W] ^ {hf_tag[0], hf_tag[TAG_W-1:1]} ^ TAG_W'(HIST_LEN);
    // zero is reserved for empty entries
    tag     = (tag_raw == '0) ? TAG_W'(1) : tag_raw;
  end
endmodule

// File: rtl/bp_tag_bank.sv
module bp_tag_bank #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8,
  parameter int CTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output logic [CTR_W-1:0] up_ctr,
  output logic             up_u,
  input  logic             wr_ctr_en,
  input  logic [CTR_W-1:0] wr_ctr,
  input  logic             wr_tag_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_u_en,
  input  logic             wr_u
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_WEAK_NT = '1;

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic             u_q   [ENTRIES];

  always_comb begin
    rd_hit = (tag_q[rd_idx] == rd_tag);
    rd_ctr = ctr_q[rd_idx];
    up_ctr = ctr_q[up_idx];
    up_u   = u_q[up_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ctr_q[e] <= CTR_WEAK_NT;
        tag_q[e] <= '0;
        u_q[e]   <= 1'b0;
      end
    end else begin
      if (wr_ctr_en) ctr_q[up_idx] <= wr_ctr;
      if (wr_tag_en) tag_q[up_idx] <= wr_tag;
      if (wr_u_en)   u_q[up_idx]   <= wr_u;
    end
  end

  // R3: an allocated tag is never the empty marker
  a_r3_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tag_en |=> tag_q[$past(up_idx)] != '0);
endmodule

// File: rtl/tage_predictor.sv
module tage_predictor #(
  parameter int PC_W       = 12,
  parameter int HIST_W     = 16,
  parameter int L1         = 4,
  parameter int L2         = 8,
  parameter int L3         = 16,
  parameter int TAG_IDX_W  = 6,
  parameter int BASE_IDX_W = 6,
  parameter int TAG_W      = 8,
  parameter int CTR_W      = 3,
  parameter int BCTR_W     = 2,
  localparam int META_W    = HIST_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [META_W-1:0] pred_meta,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [META_W-1:0] upd_meta
);
  import tage_pkg::*;

  localparam int NT = NUM_TAGGED;
  localparam int BASE_N = 1 << BASE_IDX_W;
  localparam logic [CTR_W-1:0]  CTR_MAX  = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0]  CTR_MIN  = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic [BCTR_W-1:0] BCTR_MAX = '1;
  localparam logic [BCTR_W-1:0] BCTR_INIT = BCTR_W'(1) << (BCTR_W-2);

  // ---------------- history ----------------
  logic [HIST_W-1:0] hist_q, hist_d;

  // ---------------- update metadata ----------------
  logic [HIST_W-1:0] u_ckpt;
  prov_e             u_prov;
  logic              u_alt, u_pred, upd_mis;
  always_comb begin
    u_ckpt  = upd_meta[META_W-1:4];
    u_prov  = prov_e'(upd_meta[3:2]);
    u_alt   = upd_meta[1];
    u_pred  = upd_meta[0];
    upd_mis = upd_valid && (u_pred != upd_taken);
  end

  // ---------------- base table ----------------
  logic [BCTR_W-1:0]     base_q [BASE_N];
  logic [BASE_IDX_W-1:0] bp_idx, bu_idx;
  logic [BCTR_W-1:0]     base_up, base_wr;
  logic                  base_we, base_tk;

  always_comb begin
    bp_idx  = pred_pc[BASE_IDX_W-1:0];
    bu_idx  = upd_pc[BASE_IDX_W-1:0];
    base_tk = base_q[bp_idx][BCTR_W-1];
    base_up = base_q[bu_idx];
    base_we = upd_valid && (u_prov == PROV_BASE);
    base_wr = base_up;
    if (upd_taken && base_up != BCTR_MAX)      base_wr = base_up + 1'b1;
    else if (!upd_taken && base_up != '0)      base_wr = base_up - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < BASE_N; e++) base_q[e] <= BCTR_INIT;
    end else if (base_we) begin
      base_q[bu_idx] <= base_wr;
    end
  end

  // ---------------- tagged tables ----------------
  logic [NT-1:0]        hit, up_u, cand, free_e, alloc, is_prov;
  logic [CTR_W-1:0]     rctr [NT];
  logic [CTR_W-1:0]     uctr [NT];
  logic                 clr_all;

  for (genvar k = 0; k < NT; k++) begin : g_tbl
    localparam int LEN = (k == 0) ? L1 : (k == 1) ? L2 : L3;
    logic [TAG_IDX_W-1:0] p_idx, u_idx;
    logic [TAG_W-1:0]     p_tag, u_tag;
    logic [CTR_W-1:0]     ctr_wr;
    logic                 ctr_we, u_we, u_val;

    bp_hash #(.PC_W(PC_W), .HIST_LEN(LEN), .IDX_W(TAG_IDX_W), .TAG_W(TAG_W)) u_ph (
      .pc(pred_pc), .hist(hist_q[LEN-1:0]), .idx(p_idx), .tag(p_tag));
    bp_hash #(.PC_W(PC_W), .HIST_LEN(LEN), .IDX_W(TAG_IDX_W), .TAG_W(TAG_W)) u_uh (
      .pc(upd_pc), .hist(u_ckpt[LEN-1:0]), .idx(u_idx), .tag(u_tag));

    always_comb begin
      is_prov[k] = upd_valid && (u_prov == prov_e'(k + 1));
      cand[k]    = upd_mis && (u_prov < prov_e'(k + 1));
      free_e[k]  = cand[k] && !up_u[k];
      ctr_we     = is_prov[k] || alloc[k];
      if (alloc[k])                             ctr_wr = upd_taken ? '0 : '1;
      else if (upd_taken && uctr[k] != CTR_MAX) ctr_wr = uctr[k] + 1'b1;
      else if (!upd_taken && uctr[k] != CTR_MIN) ctr_wr = uctr[k] - 1'b1;
      else                                      ctr_wr = uctr[k];
      u_we  = (is_prov[k] && (u_alt != u_pred)) || alloc[k] || (clr_all && cand[k]);
      u_val = is_prov[k] && (u_pred == upd_taken);
    end

    bp_tag_bank #(.IDX_W(TAG_IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(p_idx), .rd_tag(p_tag), .rd_hit(hit[k]), .rd_ctr(rctr[k]),
      .up_idx(u_idx), .up_ctr(uctr[k]), .up_u(up_u[k]),
      .wr_ctr_en(ctr_we), .wr_ctr(ctr_wr),
      .wr_tag_en(alloc[k]), .wr_tag(u_tag),
      .wr_u_en(u_we), .wr_u(u_val));
  end

  // lowest free longer table wins the allocation
  always_comb begin
    logic found;
    found = 1'b0;
    alloc = '0;
    for (int k = 0; k < NT; k++) begin
      alloc[k] = free_e[k] && !found;
      found    = found || free_e[k];
    end
    clr_all = (|cand) && !found;
  end

  // ---------------- provider selection ----------------
  prov_e prov;
  logic  prov_tk, alt_tk;
  always_comb begin
    prov    = PROV_BASE;
    prov_tk = base_tk;
    alt_tk  = base_tk;
    for (int k = 0; k < NT; k++) begin
      if (hit[k]) begin
        alt_tk  = prov_tk;
        prov    = prov_e'(k + 1);
        prov_tk = !rctr[k][CTR_W-1];
      end
    end
    pred_taken = prov_tk;
    pred_meta  = {hist_q, prov, alt_tk, prov_tk};
  end

  // ---------------- history next state / register ----------------
  always_comb begin
    hist_d = hist_q;
    if (pred_valid) hist_d = {hist_q[HIST_W-2:0], pred_taken};
    if (upd_mis)    hist_d = {u_ckpt[HIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // ---------------- assertions ----------------
  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && (upd_meta[0] != upd_taken) |=>
      hist_q == {$past(upd_meta[META_W-2:4]), $past(upd_taken)});

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !(upd_valid && (upd_meta[0] != upd_taken)) |=>
      hist_q == {$past(hist_q[HIST_W-2:0]), $past(pred_taken)});

  a_r4_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc));

  a_r2_base_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && (upd_meta[3:2] == 2'd0) && upd_taken && (base_up == BCTR_MAX) |=>
      base_q[$past(bu_idx)] == BCTR_MAX);
endmodule

// File: tb/tage_predictor_bench.sv
`timescale 1ns/1ps
module tage_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pred_valid, upd_valid, upd_taken;
  logic [11:0] pred_pc, upd_pc;
  logic        pred_taken;
  logic [19:0] pred_meta, upd_meta;

  int checks = 0;
  int errors = 0;
  logic        got_pred;
  logic [19:0] got_meta;

  always #2.5 clk = ~clk;

  tage_predictor u_tage_predictor (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_meta(pred_meta),
    .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_meta(upd_meta));

  // {outcome, expected prediction after training}: R2 base counter walk
  localparam logic [1:0] BASE_VEC [9] = '{
    2'b11, 2'b11, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10, 2'b11 };

  localparam logic [6:0] XPAT = 7'b0001011;

  localparam logic [11:0] PC_P = 12'h3A5;
  localparam logic [11:0] PC_R = 12'h0C2;
  localparam logic [11:0] PC_S = 12'h517;
  localparam logic [11:0] PC_L = 12'h6E8;
  localparam logic [11:0] PC_X = 12'h24C;
  localparam logic [11:0] PC_Y = 12'h9B1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pred_valid = 0; upd_valid = 0; pred_pc = '0;
    upd_pc = '0; upd_taken = 0; upd_meta = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input logic pv, input logic [11:0] ppc, input logic uv,
                    input logic [11:0] upc, input logic ut, input logic [19:0] um);
    @(negedge clk);
    pred_valid = pv; pred_pc = ppc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_meta = um;
    #1;
    got_pred = pred_taken;
    got_meta = pred_meta;
    @(posedge clk);
    #1;
    pred_valid = 0; upd_valid = 0;
  endtask

  task automatic probe(input logic [11:0] pc);
    op(1'b1, pc, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] m;
    int miss;

    // ---- base counter walk, table driven (R2) ----
    do_reset();
    foreach (BASE_VEC[i]) begin
      op(1'b0, '0, 1'b1, PC_S, BASE_VEC[i][1], {16'h0, 2'd0, 1'b0, BASE_VEC[i][1]});
      probe(PC_S);
      chk($sformatf("R2 base step %0d", i), got_pred, BASE_VEC[i][0]);
    end

    // ---- reset state (R1) ----
    do_reset();
    for (int i = 0; i < 4; i++) begin
      probe(12'h111 * i[11:0] + 12'h05);
      chk("R1 reset prediction", got_pred, 1'b0);
      chk("R1 reset provider/checkpoint", {got_meta[19:4], got_meta[3:2]}, 18'h0);
    end

    // ---- allocation, restore, shift, provider (R3..R8) ----
    probe(PC_P);
    m = got_meta;
    chk("R8 meta pred bit", m[0], 1'b0);
    op(1'b0, '0, 1'b1, PC_P, 1'b1, m);           // mispredict -> alloc table 1
    probe(PC_R);
    chk("R7 restored checkpoint", got_meta[19:4], 16'h0001);
    for (int i = 0; i < 3; i++) begin
      probe(PC_R);
      chk("R6 speculative shift", got_meta[19:4], 16'h0002 << i);
    end
    probe(PC_P);
    chk("R4 allocated provider", got_meta[3:2], 2'd1);
    chk("R4 weak taken counter", got_pred, 1'b1);
    chk("R3 longest hit gives direction", got_meta[0], 1'b1);
    // provider 1 trained toward not-taken, pretending it was correct
    op(1'b0, '0, 1'b1, PC_P, 1'b0, {16'h0, 2'd1, 1'b1, 1'b0});
    for (int i = 0; i < 4; i++) probe(PC_R);
    probe(PC_P);
    chk("R5 provider counter moved", got_pred, 1'b0);
    chk("R5 provider still table 1", got_meta[3:2], 2'd1);

    // ---- restore beats shift in the same cycle (R7) ----
    do_reset();
    op(1'b1, PC_R, 1'b1, PC_S, 1'b1, {16'h00F0, 2'd0, 1'b0, 1'b0});
    chk("R7 same-cycle checkpoint seen", got_meta[19:4], 16'h0000);
    probe(PC_R);
    chk("R7 restore over shift", got_meta[19:4], 16'h01E1);

    // ---- loop pattern T T T N (R9) ----
    do_reset();
    miss = 0;
    for (int it = 0; it < 80; it++) begin
      for (int pos = 0; pos < 4; pos++) begin
        logic t, p;
        t = (pos != 3);
        probe(PC_L);
        p = got_pred; m = got_meta;
        op(1'b0, '0, 1'b1, PC_L, t, m);
        if (it >= 60 && p != t) miss++;
      end
    end
    chk("R9 loop mispredictions", miss, 0);

    // ---- correlated pair (R10) ----
    do_reset();
    miss = 0;
    for (int it = 0; it < 140; it++) begin
      logic x, p;
      x = XPAT[it % 7];
      probe(PC_X);
      m = got_meta;
      op(1'b0, '0, 1'b1, PC_X, x, m);
      probe(PC_Y);
      p = got_pred; m = got_meta;
      op(1'b0, '0, 1'b1, PC_Y, x, m);
      if (it >= 100 && p != x) miss++;
    end
    chk("R10 correlated mispredictions", miss, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule